// File: doc/BRIEF.md
# S/PDIF User-Bit Block Double Buffer

This block supplies the per-frame user bit to an S/PDIF transmitter's frame formatter across a 192-frame block. Software stages a 192-bit user-bit image in six 32-bit staging registers through a plain write port. It then raises an update-pending flag. Transmission never reads the staging registers directly. It reads an internal shadow copy that changes only at a block boundary. Software can therefore prepare the next block's image at any point while the current block goes out.

At each boundary the pending flag is sampled. When it is set, the staged image moves into the shadow and the hardware drops the flag. When it is clear, the shadow is filled with zeros and the flag stays low. Boundaries occur in two places: on the frame-end strobe that closes frame 191, and at once when the enable rises, before frame 0. Software therefore sets the flag before it enables the transmitter, so that the first block carries its image. The output for frame n is shadow bit n. A registered-output variant can be chosen by parameter.

Top module: `usrbit_blk_buf`

## Requirements
- R1: After reset the pending flag, the user-bit output and the frame index are all 0.
- R2: A write to address i (0 to 5) stores the data word in staging register i. Bit j of register i is image bit 32*i+j, and image bit n is the user bit of frame n, so frame 0 takes bit 0 of register 0.
- R3: A write to address 6 sets the pending flag to bit 0 of the data word. A write to address 7 has no effect.
- R4: In the cycle the enable is first seen high, a boundary is taken before frame 0. If the flag is 1, the image is loaded and the flag clears.
- R5: A frame-end strobe while the frame index is 191 is a boundary. If the flag is 1 at that boundary, the staged image becomes the next block's bits and the flag clears.
- R6: At a boundary with the flag at 0, the next block's bits are all zero and the flag stays 0.
- R7: Writes to the staging registers during a block do not change the bits sent in that block.
- R8: While enabled, each frame-end strobe advances the frame index by one, and the index wraps from 191 to 0.
- R9: A software write of 1 to the flag in the same cycle as a boundary load keeps the flag at 1, so the next boundary loads again.
- R10: While the enable is low, the frame index is 0 and the output is 0, and frame-end strobes are ignored. The staging registers and the flag keep their values.
- R11: While enabled, the user-bit output during frame n is shadow bit n, valid the cycle after the boundary or strobe that opens frame n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 to 5 staging registers, 6 pending flag |
| wr_data | input | 32 | Write data |
| tx_en | input | 1 | Transmitter enable |
| frame_end | input | 1 | One-cycle strobe at the end of each frame |
| ubit_out | output | 1 | User bit of the current frame |
| frame_idx | output | 8 | Index of the current frame in the block |
| upd_pend | output | 1 | Update-pending flag |

## Verification
The in-RTL properties assume that frame_end is a single-cycle pulse. They also assume that the write address never selects two targets at once, and that the enable is held for whole cycles and never glitches. The stimulus drives every input one time unit after the rising edge. It separates frame strobes with an idle cycle. It places register writes only in the gaps between strobes, except for the single deliberate case where a flag write coincides with the block-closing strobe. That case checks the set-versus-clear priority.

// File: rtl/usrbit_pkg.sv
`timescale 1ns/1ps
package usrbit_pkg;
   // Action applied to the shadow buffer on a given cycle
   typedef enum logic [1:0] {
      SH_HOLD  = 2'd0,
      SH_IMAGE = 2'd1,
      SH_ZERO  = 2'd2
   } shadow_op_e;
endpackage

// File: rtl/usrbit_regfile.sv
`timescale 1ns/1ps
module usrbit_regfile #(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 6,
   parameter int ADDR_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [REG_W-1:0]          wr_data,
   input  logic                      blk_bnd,
   output logic [NUM_REGS*REG_W-1:0] image,
   output logic                      upd_pend
);
   localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NUM_REGS);

   logic flag_wr;
   assign flag_wr = wr_en && (wr_addr == FLAG_ADDR);

   // One staging register per slice of the image
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_stage
      logic [REG_W-1:0] stage_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            stage_q <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(g)))
            stage_q <= wr_data;
      end
      assign image[g*REG_W +: REG_W] = stage_q;
   end

   // Pending flag: a software write wins over the hardware clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         upd_pend <= 1'b0;
      else if (flag_wr)
         upd_pend <= wr_data[0];
      else if (blk_bnd)
         upd_pend <= 1'b0;
   end

   // R5: a boundary with a pending update and no software write clears the flag
   p_hw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_bnd && upd_pend && !flag_wr) |=> !upd_pend);
   // R6: a clear flag stays clear unless software sets it
   p_flag_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_pend && !flag_wr) |=> !upd_pend);
   // R9: a software set always takes effect, boundary or not
   p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wr_data[0]) |=> upd_pend);
endmodule

// File: rtl/usrbit_frame_ctr.sv
`timescale 1ns/1ps
module usrbit_frame_ctr #(
   parameter int FRAMES = 192,
   parameter int CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             frame_end,
   output logic [CNT_W-1:0] cnt,
   output logic             blk_bnd
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

   logic en_q;
   logic at_last;

   assign at_last = (cnt == LAST);
   // Boundary on enable rise, or on the strobe closing the final frame
   assign blk_bnd = tx_en && (!en_q || (frame_end && at_last));

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else
         en_q <= tx_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_en || !en_q)
         cnt <= '0;
      else if (frame_end)
         cnt <= at_last ? '0 : cnt + CNT_W'(1);
   end

   // R8: index never leaves the block
   p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   // R8: wrap after the last frame
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && en_q && frame_end && at_last) |=> (cnt == '0));
   // R8: single step on an ordinary strobe
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && en_q && frame_end && !at_last) |=> (cnt == $past(cnt) + CNT_W'(1)));
   // R10: disabled means index 0
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (cnt == '0));
endmodule

// File: rtl/usrbit_shadow.sv
`timescale 1ns/1ps
module usrbit_shadow
   import usrbit_pkg::*;
#(
   parameter int FRAMES   = 192,
   parameter int CNT_W    = 8,
   parameter bit OUT_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  shadow_op_e        op,
   input  logic [FRAMES-1:0] image,
   input  logic [CNT_W-1:0]  cnt,
   output logic              ubit_out
);
   logic [FRAMES-1:0] shadow_q;
   logic              bit_sel;

   always_ff @(posedge clk) begin
      if (!rst_n || !tx_en)
         shadow_q <= '0;
      else begin
         unique case (op)
            SH_IMAGE: shadow_q <= image;
            SH_ZERO:  shadow_q <= '0;
            default:  shadow_q <= shadow_q;
         endcase
      end
   end

   assign bit_sel = shadow_q[cnt];

   if (OUT_PIPE) begin : g_pipe
      logic ubit_q;
      always_ff @(posedge clk) begin
         if (!rst_n || !tx_en)
            ubit_q <= 1'b0;
         else
            ubit_q <= bit_sel;
      end
      assign ubit_out = ubit_q;
   end else begin : g_direct
      assign ubit_out = bit_sel;
   end

   // R5: a load captures the staged image as it stood
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && op == SH_IMAGE) |=> (shadow_q == $past(image)));
   // R6: zero fill at a boundary without update
   p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && op == SH_ZERO) |=> (shadow_q == '0));
   // R7: between boundaries the shadow is frozen
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && op == SH_HOLD) |=> $stable(shadow_q));
   // R10: disabling wipes the shadow
   p_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (shadow_q == '0));
endmodule

// File: rtl/usrbit_blk_buf.sv
`timescale 1ns/1ps
module usrbit_blk_buf
   import usrbit_pkg::*;
#(
   parameter int FRAMES   = 192,
   parameter int REG_W    = 32,
   parameter bit OUT_PIPE = 1'b0,
   localparam int NUM_REGS = FRAMES / REG_W,
   localparam int ADDR_W   = $clog2(NUM_REGS + 1),
   localparam int CNT_W    = $clog2(FRAMES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              tx_en,
   input  logic              frame_end,
   output logic              ubit_out,
   output logic [CNT_W-1:0]  frame_idx,
   output logic              upd_pend
);
   if (FRAMES % REG_W != 0) begin : g_bad_split
      $error("FRAMES must be a whole multiple of REG_W");
   end
   if (FRAMES < 2) begin : g_bad_frames
      $error("FRAMES must be at least 2");
   end

   logic                      blk_bnd;
   logic [NUM_REGS*REG_W-1:0] image;
   shadow_op_e                op;

   usrbit_regfile #(
      .REG_W   (REG_W),
      .NUM_REGS(NUM_REGS),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .blk_bnd (blk_bnd),
      .image   (image),
      .upd_pend(upd_pend)
   );

   usrbit_frame_ctr #(
      .FRAMES(FRAMES),
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .frame_end(frame_end),
      .cnt      (frame_idx),
      .blk_bnd  (blk_bnd)
   );

   always_comb begin
      if (!blk_bnd)
         op = SH_HOLD;
      else if (upd_pend)
         op = SH_IMAGE;
      else
         op = SH_ZERO;
   end

   usrbit_shadow #(
      .FRAMES  (FRAMES),
      .CNT_W   (CNT_W),
      .OUT_PIPE(OUT_PIPE)
   ) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .op      (op),
      .image   (image),
      .cnt     (frame_idx),
      .ubit_out(ubit_out)
   );

   // R4: a pending update is consumed when enable first rises
   p_first_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_bnd && upd_pend && !(wr_en && wr_addr == ADDR_W'(NUM_REGS))) |=> !upd_pend);
   // R10: nothing is sent while disabled
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !$past(tx_en)) |-> !ubit_out);
endmodule

// File: tb/sim_usrbit_blk_buf.sv
`timescale 1ns/1ps
module sim_usrbit_blk_buf;
   localparam int FR = 192;
   localparam int RW = 32;
   localparam int NR = FR / RW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        tx_en = 1'b0;
   logic        frame_end = 1'b0;
   logic        ubit_out;
   logic [7:0]  frame_idx;
   logic        upd_pend;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic  b;
      int    idx;
      string tag;
   } exp_t;
   exp_t sb[$];

   logic [FR-1:0] im_a, im_b, im_c, im_z;

   always #2.5 clk = ~clk;

   usrbit_blk_buf u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .tx_en    (tx_en),
      .frame_end(frame_end),
      .ubit_out (ubit_out),
      .frame_idx(frame_idx),
      .upd_pend (upd_pend)
   );

   function automatic logic [FR-1:0] mk_img(int seed);
      logic [FR-1:0] v;
      for (int i = 0; i < NR; i++)
         v[i*RW +: RW] = (32'h9E37_79B9 * (seed * 13 + i + 1)) ^ (32'h0F0F_3C3C << i);
      return v;
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic load_regs(logic [FR-1:0] img);
      for (int i = 0; i < NR; i++) wr(3'(i), img[i*RW +: RW]);
   endtask

   // Driver: one frame per call, expected bit queued for the monitor
   task automatic send_frame(logic b, int n, string tag, bit with_flag);
      exp_t e;
      e.b = b; e.idx = n; e.tag = tag;
      sb.push_back(e);
      frame_end = 1'b1;
      if (with_flag) begin wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'd1; end
      step();
      frame_end = 1'b0; wr_en = 1'b0;
      step();
   endtask

   task automatic run_block(logic [FR-1:0] img, string tag, int mid_at,
                            logic [FR-1:0] mid_img, bit mid_flag, bit last_flag);
      for (int n = 0; n < FR; n++) begin
         if (n == mid_at) begin
            load_regs(mid_img);
            if (mid_flag) wr(3'd6, 32'd1);
         end
         send_frame(img[n], n, (mid_at >= 0 && n >= mid_at) ? "R7" : tag,
                    last_flag && n == FR - 1);
      end
   endtask

   // Monitor: compares each frame's bit and index as the frame closes
   always @(negedge clk) begin : mon
      exp_t e;
      if (frame_end && tx_en) begin
         if (sb.size() == 0)
            check(1'b0, "R11", "scoreboard underflow", 0, 1);
         else begin
            e = sb.pop_front();
            check(ubit_out === e.b, e.tag, $sformatf("user bit of frame %0d", e.idx),
                  longint'(ubit_out), longint'(e.b));
            check(frame_idx == 8'(e.idx), "R8", "frame index", frame_idx, e.idx);
         end
      end
   end

   initial begin : wdog
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      im_a = mk_img(1); im_b = mk_img(2); im_c = mk_img(3); im_z = '0;
      repeat (4) step();
      @(negedge clk);
      check(upd_pend == 1'b0, "R1", "flag after reset", upd_pend, 0);
      check(ubit_out == 1'b0, "R1", "output after reset", ubit_out, 0);
      check(frame_idx == 8'd0, "R1", "index after reset", frame_idx, 0);
      step();
      rst_n = 1'b1;
      step();

      // R3: flag follows bit 0; address 7 is ignored
      load_regs(im_a);
      wr(3'd6, 32'd1);
      @(negedge clk);
      check(upd_pend == 1'b1, "R3", "flag set by write", upd_pend, 1);
      step();
      wr(3'd6, 32'hFFFF_FFFE);
      @(negedge clk);
      check(upd_pend == 1'b0, "R3", "flag cleared by write", upd_pend, 0);
      step();
      wr(3'd7, 32'hFFFF_FFFF);
      @(negedge clk);
      check(upd_pend == 1'b0, "R3", "address 7 ignored", upd_pend, 0);
      step();
      wr(3'd6, 32'd1);

      // R4: enable rise loads image A before frame 0
      tx_en = 1'b1;
      step();
      @(negedge clk);
      check(upd_pend == 1'b0, "R4", "flag after first load", upd_pend, 0);
      check(ubit_out == im_a[0], "R11", "frame 0 bit right after load", ubit_out, im_a[0]);
      step();

      // Block 1: image A (R2), B staged mid-block (R7)
      run_block(im_a, "R2", 50, im_b, 1'b1, 1'b0);
      @(negedge clk);
      check(upd_pend == 1'b0, "R5", "flag cleared at block end", upd_pend, 0);
      check(frame_idx == 8'd0, "R8", "wrap to 0", frame_idx, 0);
      step();

      // Block 2: image B, no new update
      run_block(im_b, "R5", -1, im_z, 1'b0, 1'b0);
      @(negedge clk);
      check(upd_pend == 1'b0, "R6", "flag stays low", upd_pend, 0);
      step();

      // Block 3: zeros; C staged, flag rewritten on the closing strobe
      run_block(im_z, "R6", 100, im_c, 1'b1, 1'b1);
      @(negedge clk);
      check(upd_pend == 1'b1, "R9", "software set beats clear", upd_pend, 1);
      step();

      // Block 4: C; flag consumed again at its end
      run_block(im_c, "R9", -1, im_z, 1'b0, 1'b0);
      @(negedge clk);
      check(upd_pend == 1'b0, "R5", "second load clears flag", upd_pend, 0);
      step();

      // Block 5: partial, then disable (R10)
      for (int n = 0; n < 10; n++) send_frame(im_c[n], n, "R9", 1'b0);
      wr(3'd6, 32'd1);
      tx_en = 1'b0;
      step();
      frame_end = 1'b1;
      step();
      frame_end = 1'b0;
      @(negedge clk);
      check(ubit_out == 1'b0, "R10", "output while disabled", ubit_out, 0);
      check(frame_idx == 8'd0, "R10", "index while disabled", frame_idx, 0);
      check(upd_pend == 1'b1, "R10", "flag kept while disabled", upd_pend, 1);
      step();
      tx_en = 1'b1;
      step();
      @(negedge clk);
      check(upd_pend == 1'b0, "R10", "reload after re-enable", upd_pend, 0);
      step();
      run_block(im_c, "R10", -1, im_z, 1'b0, 1'b0);

      @(negedge clk);
      check(sb.size() == 0, "R11", "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule